// File: doc/BRIEF.md
# Non-Overlapping Two-Phase Clock Sequencer

This block turns one fast reference clock into a pair of phase signals, each on its own output wire, that are never high together. A state machine walks a fixed cycle: a quiet gap with both phases low, the first phase high, a second quiet gap, the second phase high, and back to the start. How long each phase stays high and how long each gap lasts are counted in reference-clock cycles and set by three configuration inputs. Downstream logic that stores state in level-sensitive latches can clock one bank on each phase and rely on the quiet gaps to keep the two banks from being open at once.

Configuration is captured once per period, in the period's opening cycle, so a value written mid-period never shortens or stretches a pulse already under way. Both phase outputs and the two start strobes come straight from flip-flops, so no decoding glitch reaches the wires. After reset the machine opens a fresh period, which begins with a gap before the first pulse of phase one.

The states are ST_SYNC (first cycle of a period, both low, configuration sampled), ST_LEAD (remaining lead-gap cycles), ST_HI1 (phase one high), ST_MID (gap between the phases) and ST_HI2 (phase two high). Transitions: ST_SYNC to ST_LEAD when the gap is longer than one cycle, ST_SYNC to ST_HI1 when the gap is one cycle, ST_LEAD to ST_HI1, ST_HI1 to ST_MID, ST_MID to ST_HI2 and ST_HI2 to ST_SYNC, each taken when the running count of the current state reaches zero.

Top module: `twophase_clkgen`

## Requirements
- R1: With effective gap G, phase-one width A and phase-two width B, the period is 2G+A+B cycles long: cycle positions 0..G-1 both low, G..G+A-1 ph1_out high, then G cycles both low, then B cycles ph2_out high, then the next period starts.
- R2: ph1_out and ph2_out are never high in the same reference-clock cycle.
- R3: Between the fall of either phase and the rise of the other, both outputs stay low for at least G cycles, and G is never less than one.
- R4: Pulses alternate strictly, phase one first after reset, then phase two, then phase one again.
- R5: A configuration value of zero on any of the three inputs is treated as one cycle.
- R6: While rst_n is low, all four outputs are low; after release the period opens at position 0, so the first ph1_out pulse rises G cycles after the first cycle out of reset.
- R7: The three configuration inputs are sampled only at the clock edge that ends position 0 of a period; changes at any other time take effect in the next period.
- R8: ph1_start is high exactly in the first cycle of each ph1_out pulse, and ph2_start exactly in the first cycle of each ph2_out pulse; otherwise they are low.
- R9: With all three inputs set to one, the outputs repeat a four-cycle pattern: low, ph1_out, low, ph2_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gap_cycles | input | CFG_W | Length of each quiet gap in cycles (0 acts as 1) |
| ph1_cycles | input | CFG_W | High width of phase one in cycles (0 acts as 1) |
| ph2_cycles | input | CFG_W | High width of phase two in cycles (0 acts as 1) |
| ph1_out | output | 1 | Phase-one clock, registered |
| ph2_out | output | 1 | Phase-two clock, registered |
| ph1_start | output | 1 | One-cycle strobe on the first cycle of phase one |
| ph2_start | output | 1 | One-cycle strobe on the first cycle of phase two |

## Verification
The configuration capture and the start of the first phase can land in the same cycle: when the gap is one cycle, the edge that samples new settings is also the edge that raises ph1_out and ph1_start, and it must use the freshly sampled width. The bench provokes this by changing the inputs every cycle with a gap of zero or one, so new values are always present in the opening cycle of a period. A cycle model in the bench latches the inputs only at position 0 and predicts every output bit in every cycle, so any use of stale values or of values sampled mid-period shows up as a miscompare.

// File: rtl/twophase_pkg.sv
package twophase_pkg;

    typedef enum logic [2:0] {
        ST_SYNC = 3'd0,
        ST_LEAD = 3'd1,
        ST_HI1  = 3'd2,
        ST_MID  = 3'd3,
        ST_HI2  = 3'd4
    } tp_state_e;

    localparam int NUM_FIELDS = 3;
    localparam int FLD_GAP    = 0;
    localparam int FLD_W1     = 1;
    localparam int FLD_W2     = 2;

endpackage

// File: rtl/tp_cfg_hold.sv
module tp_cfg_hold
    import twophase_pkg::*;
#(
    parameter int CFG_W = 4
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg_in  [NUM_FIELDS],
    output logic [CFG_W-1:0] cfg_eff [NUM_FIELDS]
);

    localparam logic [CFG_W-1:0] ONE = CFG_W'(1);

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic [CFG_W-1:0] live;
        logic [CFG_W-1:0] held;

        // zero is raised to the minimum of one cycle
        assign live = (cfg_in[f] == '0) ? ONE : cfg_in[f];

        always_ff @(posedge clk_ref or negedge rst_n) begin
            if (!rst_n) begin
                held <= ONE;
            end else if (load) begin
                held <= live;
            end
        end

        // during the opening cycle the live value is used; later the held one
        assign cfg_eff[f] = load ? live : held;
    end

endmodule

// File: rtl/tp_seq_fsm.sv
module tp_seq_fsm
    import twophase_pkg::*;
#(
    parameter int CFG_W = 4
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] gap_len,
    input  logic [CFG_W-1:0] w1_len,
    input  logic [CFG_W-1:0] w2_len,
    output tp_state_e        state,
    output tp_state_e        state_nxt
);

    localparam logic [CFG_W-1:0] ONE = CFG_W'(1);
    localparam logic [CFG_W-1:0] TWO = CFG_W'(2);

    logic [CFG_W-1:0] cnt;
    logic [CFG_W-1:0] cnt_nxt;
    logic             cnt_done;

    assign cnt_done = (cnt == '0);

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt - ONE;
        unique case (state)
            ST_SYNC: begin
                if (gap_len == ONE) begin
                    state_nxt = ST_HI1;
                    cnt_nxt   = w1_len - ONE;
                end else begin
                    state_nxt = ST_LEAD;
                    cnt_nxt   = gap_len - TWO;
                end
            end
            ST_LEAD: begin
                if (cnt_done) begin
                    state_nxt = ST_HI1;
                    cnt_nxt   = w1_len - ONE;
                end
            end
            ST_HI1: begin
                if (cnt_done) begin
                    state_nxt = ST_MID;
                    cnt_nxt   = gap_len - ONE;
                end
            end
            ST_MID: begin
                if (cnt_done) begin
                    state_nxt = ST_HI2;
                    cnt_nxt   = w2_len - ONE;
                end
            end
            ST_HI2: begin
                if (cnt_done) begin
                    state_nxt = ST_SYNC;
                    cnt_nxt   = '0;
                end
            end
            default: begin
                state_nxt = ST_SYNC;
                cnt_nxt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SYNC;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

endmodule

// File: rtl/tp_out_reg.sv
module tp_out_reg
    import twophase_pkg::*;
(
    input  logic      clk_ref,
    input  logic      rst_n,
    input  tp_state_e state,
    input  tp_state_e state_nxt,
    output logic      ph1_q,
    output logic      ph2_q,
    output logic      ph1_stb,
    output logic      ph2_stb
);

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            ph1_q   <= 1'b0;
            ph2_q   <= 1'b0;
            ph1_stb <= 1'b0;
            ph2_stb <= 1'b0;
        end else begin
            ph1_q   <= (state_nxt == ST_HI1);
            ph2_q   <= (state_nxt == ST_HI2);
            ph1_stb <= (state_nxt == ST_HI1) && (state != ST_HI1);
            ph2_stb <= (state_nxt == ST_HI2) && (state != ST_HI2);
        end
    end

endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen
    import twophase_pkg::*;
#(
    parameter int CFG_W = 4
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] gap_cycles,
    input  logic [CFG_W-1:0] ph1_cycles,
    input  logic [CFG_W-1:0] ph2_cycles,
    output logic             ph1_out,
    output logic             ph2_out,
    output logic             ph1_start,
    output logic             ph2_start
);

    tp_state_e        state;
    tp_state_e        state_nxt;
    logic [CFG_W-1:0] cfg_raw [NUM_FIELDS];
    logic [CFG_W-1:0] cfg_eff [NUM_FIELDS];

    assign cfg_raw[FLD_GAP] = gap_cycles;
    assign cfg_raw[FLD_W1]  = ph1_cycles;
    assign cfg_raw[FLD_W2]  = ph2_cycles;

    tp_cfg_hold #(.CFG_W(CFG_W)) u_cfg (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .load    (state == ST_SYNC),
        .cfg_in  (cfg_raw),
        .cfg_eff (cfg_eff)
    );

    tp_seq_fsm #(.CFG_W(CFG_W)) u_fsm (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .gap_len   (cfg_eff[FLD_GAP]),
        .w1_len    (cfg_eff[FLD_W1]),
        .w2_len    (cfg_eff[FLD_W2]),
        .state     (state),
        .state_nxt (state_nxt)
    );

    tp_out_reg u_out (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .state     (state),
        .state_nxt (state_nxt),
        .ph1_q     (ph1_out),
        .ph2_q     (ph2_out),
        .ph1_stb   (ph1_start),
        .ph2_stb   (ph2_start)
    );

endmodule

// File: rtl/twophase_clkgen_chk.sv
module twophase_clkgen_chk (
    input logic clk_ref,
    input logic rst_n,
    input logic ph1_out,
    input logic ph2_out,
    input logic ph1_start,
    input logic ph2_start
);

    // set when the most recent pulse was phase one
    logic last_was_ph1;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            last_was_ph1 <= 1'b0;
        end else if (ph1_out && !ph2_out) begin
            last_was_ph1 <= 1'b1;
        end else if (ph2_out && !ph1_out) begin
            last_was_ph1 <= 1'b0;
        end
    end

    assert_no_overlap_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(ph1_out && ph2_out));

    assert_gap_before_ph1_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(ph1_out) |-> !$past(ph2_out));

    assert_gap_before_ph2_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(ph2_out) |-> !$past(ph1_out));

    assert_order_ph1_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(ph1_out) |-> !$past(last_was_ph1));

    assert_order_ph2_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(ph2_out) |-> $past(last_was_ph1));

    assert_reset_low_R6: assert property (@(posedge clk_ref)
        !rst_n |-> !(ph1_out || ph2_out || ph1_start || ph2_start));

    assert_strobe1_rise_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(ph1_out) |-> ph1_start);

    assert_strobe1_only_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ph1_start |-> (ph1_out && !$past(ph1_out)));

    assert_strobe2_rise_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(ph2_out) |-> ph2_start);

    assert_strobe2_only_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ph2_start |-> (ph2_out && !$past(ph2_out)));

endmodule

bind twophase_clkgen twophase_clkgen_chk u_chk (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .ph1_out   (ph1_out),
    .ph2_out   (ph2_out),
    .ph1_start (ph1_start),
    .ph2_start (ph2_start)
);

// File: tb/test_twophase_clkgen.sv
module test_twophase_clkgen;

    localparam int CW = 4;

    logic          clk_ref = 1'b0;
    logic          rst_n   = 1'b0;
    logic [CW-1:0] gap_cycles = '0;
    logic [CW-1:0] ph1_cycles = '0;
    logic [CW-1:0] ph2_cycles = '0;
    logic          ph1_out, ph2_out, ph1_start, ph2_start;

    int n_vec = 0;
    int n_bad = 0;
    int pos   = 0;
    int mg = 1, m1 = 1, m2 = 1;
    bit done  = 1'b0;

    always #4 clk_ref = ~clk_ref;

    twophase_clkgen #(.CFG_W(CW)) i_twophase_clkgen (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .gap_cycles (gap_cycles),
        .ph1_cycles (ph1_cycles),
        .ph2_cycles (ph2_cycles),
        .ph1_out    (ph1_out),
        .ph2_out    (ph2_out),
        .ph1_start  (ph1_start),
        .ph2_start  (ph2_start)
    );

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic bit exp_ph1(input int p, input int g, input int a);
        return (p >= g) && (p < g + a);
    endfunction

    function automatic bit exp_ph2(input int p, input int g, input int a, input int b);
        return (p >= 2*g + a) && (p < 2*g + a + b);
    endfunction

    task automatic check_bit(input string tag, input string what,
                             input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s pos=%0d actual=%0b expected=%0b (g=%0d a=%0d b=%0d)",
                     tag, what, pos, act, exp, mg, m1, m2);
        end
    endtask

    // called just after a falling edge: compare, update inputs, latch, advance
    task automatic tick(input int mode, input string tag);
        check_bit(tag, "R1 ph1_out", ph1_out, exp_ph1(pos, mg, m1));
        check_bit(tag, "R1 ph2_out", ph2_out, exp_ph2(pos, mg, m1, m2));
        check_bit(tag, "R8 ph1_start", ph1_start, pos == mg);
        check_bit(tag, "R8 ph2_start", ph2_start, pos == 2*mg + m1);
        check_bit(tag, "R2 overlap", ph1_out && ph2_out, 1'b0);
        if (mode == 1 && ($urandom % 8) == 0) begin
            gap_cycles = CW'($urandom);
            ph1_cycles = CW'($urandom);
            ph2_cycles = CW'($urandom);
        end else if (mode == 2) begin
            gap_cycles = CW'($urandom % 2);
            ph1_cycles = CW'($urandom % 3);
            ph2_cycles = CW'($urandom % 3);
        end
        if (pos == 0) begin
            mg = clamp1(int'(gap_cycles));
            m1 = clamp1(int'(ph1_cycles));
            m2 = clamp1(int'(ph2_cycles));
        end
        pos++;
        if (pos >= 2*mg + m1 + m2) pos = 0;
        @(negedge clk_ref);
    endtask

    task automatic set_cfg(input int g, input int a, input int b);
        gap_cycles = CW'(g);
        ph1_cycles = CW'(b == -1 ? a : a);
        ph2_cycles = CW'(b);
    endtask

    task automatic release_reset();
        rst_n = 1'b1;
        pos   = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // reset state (R6)
        set_cfg(3, 2, 2);
        repeat (3) @(negedge clk_ref);
        check_bit("R6", "reset ph1_out", ph1_out, 1'b0);
        check_bit("R6", "reset ph2_out", ph2_out, 1'b0);
        check_bit("R6", "reset ph1_start", ph1_start, 1'b0);
        check_bit("R6", "reset ph2_start", ph2_start, 1'b0);

        // first period after reset: gap first, phase one leads (R4, R6)
        release_reset();
        repeat (30) tick(0, "R4");

        // minimum settings: four-cycle pattern (R9)
        set_cfg(1, 1, 1);
        repeat (24) tick(0, "R9");

        // zero settings act as one (R5)
        set_cfg(0, 0, 0);
        repeat (24) tick(0, "R5");

        // long gaps (R3)
        set_cfg(15, 2, 3);
        repeat (120) tick(0, "R3");

        // change settings every cycle, short gap: capture meets phase start (R7)
        repeat (400) tick(2, "R7");

        // mid-phase reset (R6)
        set_cfg(2, 5, 4);
        repeat (7) tick(0, "R6");
        rst_n = 1'b0;
        #1;
        check_bit("R6", "async ph1_out", ph1_out, 1'b0);
        check_bit("R6", "async ph2_out", ph2_out, 1'b0);
        @(negedge clk_ref);
        check_bit("R6", "held ph1_start", ph1_start, 1'b0);
        release_reset();
        repeat (40) tick(0, "R6");

        // random settings changed at random moments (R1, R7)
        repeat (3000) tick(1, "R1");
        repeat (1000) tick(1, "R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule